// File: doc/BRIEF.md
# Row Scan Shift Register with Drive-Level Encoding

This block is the row (common) side of an 80-output display driver. A single select bit is walked across the outputs, one stage per line-clock pulse, and every stage is turned into a 2-bit drive-level code. A downstream analog stage uses the code to pick one of four bias voltages. The line clock is a plain input that is synchronous to the system clock. The block detects its rising edge and moves the register by one stage on each edge.

There are two chain topologies. In single mode all stages form one long chain. In dual mode the register is split into two independent half chains, each with its own serial input, so two panels can be scanned at half duty. A direction input reverses the shift direction. It also swaps the roles of the left and right edge pins: one becomes the serial input and the other the cascade output, which comes with an output-enable. The middle pin only serves as the second input in dual mode. A frame-polarity input and an active-low blanking input feed the level mapping.

Top module: `row_scan_driver`

## Requirements
- R1: The register shifts by exactly one stage per rising edge of `line_clk_i`, as seen at a `clk_i` edge. A line clock held high or held low causes no further shift. Reset clears every stage to 0.
- R2: With `dual_i`=0 and `rev_i`=0, `pin_l_i` enters stage 0 and bits move toward stage ROWS-1. `pin_r_o` shows stage ROWS-1 with `pin_r_oe_o`=1, and `pin_l_oe_o`=0.
- R3: With `dual_i`=0 and `rev_i`=1, `pin_r_i` enters stage ROWS-1 and bits move toward stage 0. `pin_l_o` shows stage 0 with `pin_l_oe_o`=1, and `pin_r_oe_o`=0.
- R4: With `dual_i`=1 and `rev_i`=0, `pin_l_i` enters stage 0 and the lower half ends at stage ROWS/2-1, without passing into the upper half. `pin_m_i` enters stage ROWS/2 and `pin_r_o` shows stage ROWS-1.
- R5: With `dual_i`=1 and `rev_i`=1, `pin_r_i` enters stage ROWS-1 and the upper half ends at stage ROWS/2. `pin_m_i` enters stage ROWS/2-1 and `pin_l_o` shows stage 0.
- R6: Stage k drives `level_o[2k+1:2k]`. The codes are V0=00, V12=01, V43=10 and V5=11. With `blank_ni`=1: frame 0 with bit 0 gives V12, frame 0 with bit 1 gives V5, frame 1 with bit 0 gives V43, and frame 1 with bit 1 gives V0.
- R7: With `blank_ni`=0 every code is V0 (00). Shifting goes on unaffected, and the stored pattern reappears once `blank_ni` returns to 1.
- R8: Pins that are not inputs in the current mode have no effect on the register. An edge output pin whose enable is 0 is driven 0, and exactly one of the two enables is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_clk_i | input | 1 | Line clock, synchronous to clk_i; its rising edge shifts the register |
| dual_i | input | 1 | 0: one chain, 1: two half chains |
| rev_i | input | 1 | 0: shift left to right, 1: right to left |
| frame_i | input | 1 | Frame polarity for level mapping |
| blank_ni | input | 1 | Active-low display blank, forces V0 |
| pin_l_i | input | 1 | Left edge pin, input value |
| pin_m_i | input | 1 | Middle pin, second input in dual mode |
| pin_r_i | input | 1 | Right edge pin, input value |
| pin_l_o | output | 1 | Left edge pin, cascade output value |
| pin_l_oe_o | output | 1 | Left edge pin output enable |
| pin_r_o | output | 1 | Right edge pin, cascade output value |
| pin_r_oe_o | output | 1 | Right edge pin output enable |
| level_o | output | 2*ROWS | Drive-level code per stage |

## Verification
On every cycle the assertions check the following:
- the register holds between line-clock edges;
- blanking forces V0 everywhere;
- exactly one edge pin is enabled;
- the cascade pin agrees with the end stage seen through the level codes;
- the correct entry pin lands in the head stage of each chain after an edge.

Only the bench scenarios show whole-register ordering over many shifts. They also show that the two halves stay independent in dual mode, that direction and mode changes in mid-pattern work, that unused pins are ignored, and that the stored pattern comes back after blanking.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  typedef enum logic [1:0] {
    LVL_V0  = 2'b00,
    LVL_V12 = 2'b01,
    LVL_V43 = 2'b10,
    LVL_V5  = 2'b11
  } drive_lvl_e;

  function automatic drive_lvl_e drive_code(input logic sel, input logic frame,
                                            input logic blank_n);
    if (!blank_n)   return LVL_V0;
    else if (frame) return sel ? LVL_V0 : LVL_V43;
    else            return sel ? LVL_V5 : LVL_V12;
  endfunction
endpackage

// File: rtl/row_edge_detect.sv
module row_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;
  // reset high: a line clock already high at reset release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sig_q <= 1'b1;
    else         sig_q <= sig_i;
  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/row_half_chain.sv
module row_half_chain #(
  parameter int LEN = 40
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  input  logic           rev_i,
  input  logic           din_i,
  output logic [LEN-1:0] q_o
);
  logic [LEN-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     q_q <= '0;
    else if (step_i) q_q <= rev_i ? {din_i, q_q[LEN-1:1]} : {q_q[LEN-2:0], din_i};

  assign q_o = q_q;
endmodule

// File: rtl/row_level_map.sv
module row_level_map #(
  parameter int ROWS = 80
) (
  input  logic [ROWS-1:0]   sel_i,
  input  logic              frame_i,
  input  logic              blank_ni,
  output logic [2*ROWS-1:0] level_o
);
  import row_scan_pkg::*;
  for (genvar k = 0; k < ROWS; k++) begin : g_stage
    assign level_o[2*k+1 -: 2] = drive_code(sel_i[k], frame_i, blank_ni);
  end
endmodule

// File: rtl/row_scan_driver.sv
module row_scan_driver #(
  parameter int ROWS = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_clk_i,
  input  logic              dual_i,
  input  logic              rev_i,
  input  logic              frame_i,
  input  logic              blank_ni,
  input  logic              pin_l_i,
  input  logic              pin_m_i,
  input  logic              pin_r_i,
  output logic              pin_l_o,
  output logic              pin_l_oe_o,
  output logic              pin_r_o,
  output logic              pin_r_oe_o,
  output logic [2*ROWS-1:0] level_o
);
  localparam int HALF = ROWS / 2;

  logic            step;
  logic            lo_din, hi_din;
  logic [HALF-1:0] lo_q, hi_q;

  row_edge_detect u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .sig_i(line_clk_i), .rise_o(step)
  );

  // single mode chains the halves; dual mode feeds the output-side half from the middle pin
  always_comb begin
    if (!rev_i) begin
      lo_din = pin_l_i;
      hi_din = dual_i ? pin_m_i : lo_q[HALF-1];
    end else begin
      hi_din = pin_r_i;
      lo_din = dual_i ? pin_m_i : hi_q[0];
    end
  end

  row_half_chain #(.LEN(HALF)) u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .rev_i(rev_i),
    .din_i(lo_din), .q_o(lo_q)
  );

  row_half_chain #(.LEN(HALF)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .rev_i(rev_i),
    .din_i(hi_din), .q_o(hi_q)
  );

  assign pin_r_oe_o = ~rev_i;
  assign pin_l_oe_o = rev_i;
  assign pin_r_o    = rev_i ? 1'b0 : hi_q[HALF-1];
  assign pin_l_o    = rev_i ? lo_q[0] : 1'b0;

  row_level_map #(.ROWS(ROWS)) u_map (
    .sel_i({hi_q, lo_q}), .frame_i(frame_i), .blank_ni(blank_ni), .level_o(level_o)
  );
endmodule

// File: rtl/row_scan_checker.sv
module row_scan_checker #(
  parameter int ROWS = 80
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_clk_i,
  input logic              dual_i,
  input logic              rev_i,
  input logic              frame_i,
  input logic              blank_ni,
  input logic              pin_l_i,
  input logic              pin_m_i,
  input logic              pin_r_i,
  input logic              pin_l_o,
  input logic              pin_l_oe_o,
  input logic              pin_r_o,
  input logic              pin_r_oe_o,
  input logic [2*ROWS-1:0] level_o
);
  localparam int HALF = ROWS / 2;

  logic lc_q, edge_seen;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lc_q <= 1'b1;
    else         lc_q <= line_clk_i;
  assign edge_seen = line_clk_i & ~lc_q;

  function automatic logic bit_of(input logic [1:0] code, input logic frame);
    return frame ? (code == 2'b00) : (code == 2'b11);
  endfunction

  logic b_first, b_last, b_mid_hi, b_mid_lo;
  assign b_first  = bit_of(level_o[1:0], frame_i);
  assign b_last   = bit_of(level_o[2*ROWS-1 -: 2], frame_i);
  assign b_mid_hi = bit_of(level_o[2*HALF+1 -: 2], frame_i);
  assign b_mid_lo = bit_of(level_o[2*HALF-1 -: 2], frame_i);

  AST_OE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({pin_l_oe_o, pin_r_oe_o}) == 1 &&
    (pin_l_oe_o || !pin_l_o) && (pin_r_oe_o || !pin_r_o));                          // R8

  AST_BLANK_V0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |-> level_o == '0);                                                   // R7

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_seen |=> ($stable(level_o) || !$stable(frame_i) || !$stable(blank_ni)));  // R1

  AST_FWD_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_seen && !rev_i) |=> (!blank_ni || b_first == $past(pin_l_i)));            // R2

  AST_FWD_CASCADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && !rev_i) |-> pin_r_o == b_last);                                    // R2

  AST_REV_CASCADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && rev_i) |-> pin_l_o == b_first);                                    // R3

  AST_DUAL_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_seen && dual_i && !rev_i) |=> (!blank_ni || b_mid_hi == $past(pin_m_i))); // R4

  AST_DUAL_MID_REV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_seen && dual_i && rev_i) |=> (!blank_ni || b_mid_lo == $past(pin_m_i)));  // R5

  AST_REV_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_seen && rev_i) |=> (!blank_ni || b_last == $past(pin_r_i)));              // R3
endmodule

bind row_scan_driver row_scan_checker #(.ROWS(ROWS)) u_chk (.*);

// File: tb/sim_row_scan_driver.sv
module sim_row_scan_driver;
  localparam int ROWS = 80;
  localparam int HALF = ROWS / 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic line_clk = 0, dual = 0, rev = 0, frame = 0, blank_n = 1;
  logic pl = 0, pm = 0, pr = 0;
  logic pl_o, pl_oe, pr_o, pr_oe;
  logic [2*ROWS-1:0] level;

  int n_chk = 0, n_fail = 0;
  logic [ROWS-1:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  row_scan_driver #(.ROWS(ROWS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_clk_i(line_clk), .dual_i(dual), .rev_i(rev),
    .frame_i(frame), .blank_ni(blank_n), .pin_l_i(pl), .pin_m_i(pm), .pin_r_i(pr),
    .pin_l_o(pl_o), .pin_l_oe_o(pl_oe), .pin_r_o(pr_o), .pin_r_oe_o(pr_oe), .level_o(level)
  );

  function automatic logic [1:0] exp_code(logic b, logic f, logic bn);
    if (!bn) return 2'b00;
    if (f)   return b ? 2'b00 : 2'b10;
    return b ? 2'b11 : 2'b01;
  endfunction

  function automatic logic [2*ROWS-1:0] exp_level(logic [ROWS-1:0] st, logic f, logic bn);
    logic [2*ROWS-1:0] v;
    for (int k = 0; k < ROWS; k++) v[2*k+1 -: 2] = exp_code(st[k], f, bn);
    return v;
  endfunction

  function automatic logic [ROWS-1:0] next_state(logic [ROWS-1:0] c, logic d, logic rv,
                                                 logic l, logic m, logic r);
    logic [ROWS-1:0] n;
    if (!rv) begin
      n[0] = l;
      for (int i = 1; i < ROWS; i++) n[i] = c[i-1];
      if (d) n[HALF] = m;
    end else begin
      n[ROWS-1] = r;
      for (int i = 0; i < ROWS-1; i++) n[i] = c[i+1];
      if (d) n[HALF-1] = m;
    end
    return n;
  endfunction

  task automatic check_all(string tag);
    logic [2*ROWS-1:0] ev;
    logic [3:0] ep, ap;
    ev = exp_level(model, frame, blank_n);
    ep = {rev ? model[0] : 1'b0, rev, rev ? 1'b0 : model[ROWS-1], ~rev};
    ap = {pl_o, pl_oe, pr_o, pr_oe};
    n_chk++;
    if (level !== ev || ap !== ep) begin
      n_fail++;
      $display("FAIL %s level=%h exp=%h pins=%b exp=%b", tag, level, ev, ap, ep);
    end
  endtask

  // one line-clock pulse: high for one cycle, low for one cycle
  task automatic pulse(logic l, logic m, logic r);
    @(negedge clk);
    pl = l; pm = m; pr = r; line_clk = 1;
    @(negedge clk);
    line_clk = 0;
    model = next_state(model, dual, rev, l, m, r);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog R1 expired, exp=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a17));
    line_clk = 1;  // high across reset release: not an edge
    #(CLK_PERIOD*3); @(negedge clk); rst_n = 1;
    @(negedge clk); check_all("R1 reset");
    line_clk = 0;

    // R2 single forward: walking one reaches the cascade pin after ROWS pulses
    pulse(1, 1, 1);
    for (int i = 1; i < ROWS; i++) pulse(0, 1, 1);  // m,r ignored (R8)
    check_all("R2 walk end / R8 ignored pins");
    pulse(0, 0, 0);
    check_all("R2 shifted out");

    // R1 held-high line clock shifts once only
    @(negedge clk); pl = 1; line_clk = 1;
    model = next_state(model, dual, rev, 1, 0, 0);
    for (int i = 0; i < 5; i++) begin @(negedge clk); pl = i[0]; end
    line_clk = 0;
    check_all("R1 held high");
    for (int i = 0; i < 5; i++) begin @(negedge clk); pl = ~pl; pm = ~pm; pr = ~pr; end
    check_all("R1 no edge");

    // R6 level table on a mixed pattern
    pulse(0, 0, 0); pulse(1, 0, 0);
    for (int f = 0; f < 2; f++) begin
      @(negedge clk); frame = f[0];
      @(negedge clk); check_all("R6 level table");
    end
    // R7 blank then restore
    @(negedge clk); blank_n = 0;
    pulse(1, 0, 0);
    check_all("R7 blank all V0");
    @(negedge clk); blank_n = 1;
    @(negedge clk); check_all("R7 pattern restored");

    // R3 single reverse
    rev = 1;
    pulse(1, 1, 1);
    for (int i = 0; i < 5; i++) pulse(1, 1, 0);  // left/mid ignored
    check_all("R3 reverse entry");

    // R4 dual forward: middle lands in stage HALF, lower tail does not cross
    rev = 0; dual = 1;
    for (int i = 0; i < HALF; i++) pulse(i == 0, 0, 1);
    check_all("R4 lower tail at HALF-1");
    pulse(0, 1, 0);
    check_all("R4 middle at HALF, no crossing");

    // R5 dual reverse
    rev = 1;
    for (int i = 0; i < 3; i++) pulse(1, 0, 1);
    pulse(0, 1, 0);
    check_all("R5 middle at HALF-1");

    // random mix
    for (int blk = 0; blk < 12; blk++) begin
      dual = $urandom_range(0, 1); rev = $urandom_range(0, 1);
      for (int i = 0; i < 40; i++) begin
        frame = $urandom_range(0, 1);
        blank_n = ($urandom_range(0, 9) != 0);
        pulse($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
        case ({dual, rev})
          2'b00: check_all("R2 random");
          2'b01: check_all("R3 random");
          2'b10: check_all("R4 random");
          default: check_all("R5 random");
        endcase
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule